// File: doc/BRIEF.md
# Width-Selectable Status Flag Unit

This block forms the add/subtract result of a 16-bit datapath and keeps the processor status word that comes with it. A data-width bit held in the status word switches the arithmetic between 16 and 8 bits at run time. The switch moves the bit that the negative flag takes. It also moves the signed range outside which the overflow flag is raised. A second held bit tells the index registers whether they run wide or narrow.

The flags change on arithmetic results and on data moves. They also change on two external overflow indications, one from a divider whose quotient does not fit and one from a 32-bit accumulator. Software can force any held bit to 1 or to 0 through set and clear masks, and a separate strobe clears the overflow flag. Flags are registered and appear on `status_o` one clock after the event. The result is combinational.

Status word layout: bits 3:0 are general held bits that only the masks change, bit 4 is the index-width bit x, bit 5 is the data-width bit m, bit 6 is overflow V, bit 7 is negative N, bits 10:8 are the interrupt priority level, and bits 15:11 are always 0.

Top module: `psw_flag_unit`

## Requirements
- R1: With m=0, `result_o` is op_a + op_b modulo 2^16 when sub_i=0, and op_a - op_b modulo 2^16 when sub_i=1.
- R2: With m=1, `result_o[7:0]` is the same sum or difference modulo 256, and `result_o[15:8]` equals `op_a_i[15:8]`.
- R3: With m=0, a cycle with alu_en_i=1 sets V (bit 6) when the signed 16-bit add or subtract result lies outside -32768..+32767, and clears V otherwise.
- R4: With m=1, a cycle with alu_en_i=1 sets V when the signed result of the low bytes lies outside -128..+127, and clears V otherwise.
- R5: With alu_en_i=1, N (bit 7) takes result bit 15 when m=0 and result bit 7 when m=1. With xfer_en_i=1 and alu_en_i=0, N takes bit 15 (m=0) or bit 7 (m=1) of op_a_i, and V is unchanged.
- R6: With no mask operation active, div_ovf_i=1 or acc_ovf_i=1 sets V, whether or not alu_en_i is high.
- R7: set_en_i sets every status bit whose mask_i bit is 1. clr_en_i clears every such bit, and clear wins over set on the same bit. clv_i clears V. Bits whose mask bit is 0 are unchanged.
- R8: In a cycle with any of set_en_i, clr_en_i or clv_i active, arithmetic, transfer and external overflow updates are ignored.
- R9: `status_o[15:11]` always reads 0, even after a set mask of all ones.
- R10: `index_wide_o` is 1 when x (bit 4) is 0 and 0 when x is 1.
- R11: After reset, `status_o` is 0, so the unit starts in 16-bit data and index mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 16 | First operand; transfer data for N |
| op_b_i | input | 16 | Second operand |
| sub_i | input | 1 | 1 subtract, 0 add |
| alu_en_i | input | 1 | Update N and V from the arithmetic result |
| xfer_en_i | input | 1 | Update N from op_a_i (data move) |
| div_ovf_i | input | 1 | Divide quotient too large |
| acc_ovf_i | input | 1 | 32-bit accumulate left signed range |
| set_en_i | input | 1 | Set status bits selected by mask_i |
| clr_en_i | input | 1 | Clear status bits selected by mask_i |
| clv_i | input | 1 | Clear overflow flag |
| mask_i | input | 16 | Bit mask for set/clear |
| result_o | output | 16 | Add/subtract result |
| status_o | output | 16 | Status word |
| index_wide_o | output | 1 | 1 selects 16-bit index registers |

## Verification
`result_o` is combinational, so the bench reads it 1 ns after it drives operands on the falling edge, within the same cycle. N, V, the mask effects and `index_wide_o` pass through the one status register. The bench reads them on the falling edge after the next rising edge, one cycle after the stimulus. Only then does it drop the enables, so no stimulus lasts into a second update.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned STAT_W   = 11;
  localparam int unsigned X_BIT    = 4;
  localparam int unsigned M_BIT    = 5;
  localparam int unsigned V_BIT    = 6;
  localparam int unsigned N_BIT    = 7;
endpackage

// File: rtl/psw_addsub.sv
module psw_addsub #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              narrow_i,
  output logic [DATA_W-1:0] res_o,
  output logic              neg_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0]   b_eff;
  logic [DATA_W-1:0]   full_sum;
  logic [NARROW_W-1:0] lo_sum;
  logic sa, sb, sr;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign full_sum = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
  assign lo_sum   = a_i[NARROW_W-1:0] + b_eff[NARROW_W-1:0] + {{(NARROW_W-1){1'b0}}, sub_i};

  generate
    if (DATA_W > NARROW_W) begin : g_split
      // narrow mode keeps the upper part of operand a
      assign res_o = narrow_i ? {a_i[DATA_W-1:NARROW_W], lo_sum} : full_sum;
    end else begin : g_flat
      assign res_o = full_sum;
    end
  endgenerate

  assign sa = narrow_i ? a_i[NARROW_W-1]   : a_i[DATA_W-1];
  assign sb = narrow_i ? b_eff[NARROW_W-1] : b_eff[DATA_W-1];
  assign sr = narrow_i ? lo_sum[NARROW_W-1] : full_sum[DATA_W-1];
  assign neg_o = sr;
  assign ovf_o = (sa == sb) && (sr != sa);

  // R3 R4: overflow only when raw operand signs permit it
  always_comb begin
    if (ovf_o === 1'b1) begin
      a_r3_ovf_operand_signs: assert (narrow_i ? ((a_i[NARROW_W-1] ^ b_i[NARROW_W-1]) == sub_i)
                                               : ((a_i[DATA_W-1] ^ b_i[DATA_W-1]) == sub_i));
    end
  end
endmodule

// File: rtl/psw_status.sv
module psw_status
  import psw_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arith_en_i,
  input  logic         xfer_en_i,
  input  logic         arith_n_i,
  input  logic         arith_v_i,
  input  logic         xfer_n_i,
  input  logic         ext_ovf_i,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic         clv_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         mask_op;

  assign mask_op = set_en_i | clr_en_i | clv_i;

  always_comb begin
    stat_d = stat_q;
    if (mask_op) begin
      if (set_en_i) stat_d = stat_d | mask_i;
      if (clr_en_i) stat_d = stat_d & ~mask_i;
      if (clv_i)    stat_d[V_BIT] = 1'b0;
    end else if (arith_en_i) begin
      stat_d[N_BIT] = arith_n_i;
      stat_d[V_BIT] = arith_v_i | ext_ovf_i;
    end else begin
      if (xfer_en_i) stat_d[N_BIT] = xfer_n_i;
      if (ext_ovf_i) stat_d[V_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  a_r7_clear_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((stat_q & $past(mask_i)) == '0));
  a_r7_set_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_en_i && !clv_i) |=> ((stat_q & $past(mask_i)) == $past(mask_i)));
  a_r7_clv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clv_i |=> !stat_q[V_BIT]);
  a_r6_ext_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_ovf_i && !mask_op) |=> stat_q[V_BIT]);
  a_r8_mask_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_op && !(set_en_i && mask_i[N_BIT]) && !(clr_en_i && mask_i[N_BIT]))
      |=> $stable(stat_q[N_BIT]));
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              sub_i,
  input  logic              alu_en_i,
  input  logic              xfer_en_i,
  input  logic              div_ovf_i,
  input  logic              acc_ovf_i,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic              clv_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] status_o,
  output logic              index_wide_o
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat;
  logic narrow, arith_n, arith_v, xfer_n;

  assign narrow = stat[M_BIT];
  assign xfer_n = narrow ? op_a_i[NARROW_W-1] : op_a_i[DATA_W-1];

  psw_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_addsub (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .sub_i    (sub_i),
    .narrow_i (narrow),
    .res_o    (result_o),
    .neg_o    (arith_n),
    .ovf_o    (arith_v)
  );

  psw_status #(.W(STAT_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arith_en_i (alu_en_i),
    .xfer_en_i  (xfer_en_i),
    .arith_n_i  (arith_n),
    .arith_v_i  (arith_v),
    .xfer_n_i   (xfer_n),
    .ext_ovf_i  (div_ovf_i | acc_ovf_i),
    .set_en_i   (set_en_i),
    .clr_en_i   (clr_en_i),
    .clv_i      (clv_i),
    .mask_i     (mask_i[STAT_W-1:0]),
    .stat_o     (stat)
  );

  assign status_o     = {{PAD_W{1'b0}}, stat};
  assign index_wide_o = ~stat[X_BIT];

  // R5: transfer alone leaves V untouched
  a_r5_xfer_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_en_i && !alu_en_i && !div_ovf_i && !acc_ovf_i && !set_en_i && !clr_en_i && !clv_i)
      |=> $stable(status_o[V_BIT]));
  // R2: narrow arithmetic keeps the upper byte of op_a
  a_r2_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[M_BIT] |-> (result_o[DATA_W-1:NARROW_W] == op_a_i[DATA_W-1:NARROW_W]));
endmodule

// File: tb/tb_psw_flag_unit.sv
module tb_psw_flag_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0, mask = '0;
  logic        sub = 0, alu_en = 0, xfer_en = 0, div_ovf = 0, acc_ovf = 0;
  logic        set_en = 0, clr_en = 0, clv = 0;
  logic [15:0] result, status;
  logic        index_wide;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b), .sub_i(sub),
    .alu_en_i(alu_en), .xfer_en_i(xfer_en), .div_ovf_i(div_ovf), .acc_ovf_i(acc_ovf),
    .set_en_i(set_en), .clr_en_i(clr_en), .clv_i(clv), .mask_i(mask),
    .result_o(result), .status_o(status), .index_wide_o(index_wide)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alu_en = 0; xfer_en = 0; div_ovf = 0; acc_ovf = 0;
    set_en = 0; clr_en = 0; clv = 0; mask = '0;
  endtask

  task automatic mask_op(input bit s, input bit c, input logic [15:0] m);
    set_en = s; clr_en = c; mask = m; tick(); idle();
  endtask

  // one arithmetic vector; status expected to hold mode bits mode_bits
  task automatic arith(input logic [15:0] a, input logic [15:0] b, input bit s,
                       input bit narrow, input logic [15:0] mode_bits, input bit full_chk);
    int ra, rb, r;
    logic [15:0] er;
    bit ev, en;
    op_a = a; op_b = b; sub = s; alu_en = 1;
    if (narrow) begin
      ra = int'($signed(a[7:0])); rb = int'($signed(b[7:0]));
      r = s ? ra - rb : ra + rb;
      er = {a[15:8], 8'(r)};
      ev = (r > 127) || (r < -128);
      en = er[7];
    end else begin
      ra = int'($signed(a)); rb = int'($signed(b));
      r = s ? ra - rb : ra + rb;
      er = 16'(r);
      ev = (r > 32767) || (r < -32768);
      en = er[15];
    end
    #1;
    if (full_chk || result !== er)
      chk(narrow ? "R2 narrow result" : "R1 wide result", result, er);
    tick();
    alu_en = 0;
    if (full_chk || status !== (mode_bits | {8'h0, en, ev, 6'h0}))
      chk(narrow ? "R4 R5 narrow flags" : "R3 R5 wide flags", status,
          mode_bits | {8'h0, en, ev, 6'h0});
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2);
    chk("R11 reset status", status, 16'h0000);
    chk("R10 reset index wide", {15'h0, index_wide}, 16'h0001);
    @(negedge clk); rst_n = 1; tick();
    chk("R11 status after release", status, 16'h0000);
  endtask

  task automatic t_wide();
    logic [15:0] edges [10] = '{16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF, 16'h0000,
                                16'h7FFE, 16'h8001, 16'h4000, 16'hC000, 16'h00FF};
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        arith(edges[i], edges[j], 0, 0, 16'h0, 1);
        arith(edges[i], edges[j], 1, 0, 16'h0, 1);
      end
    for (int k = 0; k < 800; k++)
      arith(16'($urandom), 16'($urandom), k[0], 0, 16'h0, 0);
    checks++;
  endtask

  task automatic t_narrow_exhaustive();
    mask_op(1, 0, 16'h0020);
    chk("R4 m set", status, 16'h0020);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          arith({8'(a ^ 8'h5A), 8'(a)}, {8'(b), 8'(b)}, s[0], 1, 16'h0020, 0);
    checks++;
    arith(16'h127F, 16'h0001, 0, 1, 16'h0020, 1);
    arith(16'h3480, 16'h0001, 1, 1, 16'h0020, 1);
    arith(16'hAB12, 16'h34FF, 0, 1, 16'h0020, 1);
  endtask

  task automatic t_xfer();
    mask_op(0, 1, 16'hFFFF);
    op_a = 16'h8000; xfer_en = 1; tick(); idle();
    chk("R5 xfer wide N", status, 16'h0080);
    mask_op(1, 0, 16'h0060);
    op_a = 16'h8000; xfer_en = 1; tick(); idle();
    chk("R5 xfer narrow N=0 V kept", status, 16'h0060);
    op_a = 16'h0080; xfer_en = 1; tick(); idle();
    chk("R5 xfer narrow N=1", status, 16'h00E0);
    mask_op(0, 1, 16'hFFFF);
  endtask

  task automatic t_ext();
    div_ovf = 1; tick(); idle();
    chk("R6 div overflow", status, 16'h0040);
    mask_op(0, 1, 16'h0040);
    op_a = 16'h8000; op_b = 16'h0001; sub = 0; alu_en = 1; acc_ovf = 1; tick(); idle();
    chk("R6 acc overflow with alu", status, 16'h00C0);
    mask_op(0, 1, 16'hFFFF);
    clv = 1; div_ovf = 1; tick(); idle();
    chk("R8 clv beats div overflow", status, 16'h0000);
  endtask

  task automatic t_masks();
    mask_op(1, 0, 16'hFFFF);
    chk("R9 upper bits zero", status, 16'h07FF);
    chk("R10 x=1 narrow index", {15'h0, index_wide}, 16'h0000);
    mask_op(0, 1, 16'h0F0F);
    chk("R7 clear mask", status, 16'h00F0);
    mask_op(1, 1, 16'h0003);
    chk("R7 clear wins over set", status, 16'h00F0);
    mask_op(0, 1, 16'hFFFF);
    chk("R7 clear all", status, 16'h0000);
    chk("R10 x=0 wide index", {15'h0, index_wide}, 16'h0001);
    op_a = 16'h7FFF; op_b = 16'h0001; sub = 0; alu_en = 1; set_en = 1; mask = 16'h0001;
    tick(); idle();
    chk("R8 mask op wins over alu", status, 16'h0001);
    mask_op(1, 0, 16'h0040);
    clv = 1; tick(); idle();
    chk("R7 clv clears V only", status, 16'h0001);
    mask_op(0, 1, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_wide();
    t_masks();
    t_xfer();
    t_ext();
    t_narrow_exhaustive();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule